// File: doc/BRIEF.md
# Sparse Prefix-Tree Hybrid Adder

This block is a purely combinational adder. It takes two WIDTH-bit operands and a carry-in and returns the WIDTH-bit sum and the carry-out. WIDTH is a parameter and must be a multiple of the group size GROUP, which defaults to 4. If it is not, elaboration stops with an error.

The carry logic is split in two levels. First, every bit gets a generate flag (both operand bits set) and a propagate flag (operand bits differ). Each GROUP-bit slice folds its flags into one group generate/propagate pair. A logarithmic-depth, Kogge-Stone-pattern prefix network then runs over the group pairs only. A final merge with the carry-in gives the carry into the bottom of every group. Inside each group, a short ripple chain seeded by that carry forms the sum bits.

A second module computes every carry with a full-width prefix network. It is provided so that both structures can be compared for equivalence.

Top module: `sparse_tree_adder`

## Requirements
- R1: For every input, sum_out equals the low WIDTH bits of a_in + b_in + carry_in, for WIDTH = 8 and WIDTH = 32.
- R2: carry_out equals bit WIDTH of a_in + b_in + carry_in.
- R3: The carry that leaves each group through its ripple chain equals the carry that the prefix network delivers to the next group. A carry started in bit 0 reaches the top group when all higher bits propagate.
- R4: A group whose bits produce a group generate always hands a carry of 1 to the next group. A group whose bits all propagate hands on its incoming carry unchanged.
- R5: When a_in XOR b_in is all ones, carry_out equals carry_in. In that case sum_out is all ones for carry_in = 0 and all zeros for carry_in = 1.
- R6: When b_in is zero, sum_out equals a_in + carry_in. With both operands zero, sum_out equals carry_in in bit 0 and carry_out is 0.
- R7: When both operands are all ones, carry_out is 1 and sum_out is all ones in bits WIDTH-1..1, with carry_in in bit 0.
- R8: The full-width prefix variant `full_tree_adder` gives the same sum and carry-out as `sparse_tree_adder` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Some properties are checked by the embedded assertions on every evaluation:
- the hand-off between each group's ripple chain and the tree carry;
- the forcing effect of group generate and group propagate;
- that a generate at the top of a span survives the prefix network;
- the closed-form results for a zero operand, full propagation and all-ones operands.

Other properties can only be shown by the bench's scenarios. These are that the arithmetic result is correct for arbitrary operands and that the sparse and full-width structures agree. For this, the bench runs every 8-bit operand pair with both carry-in values, 32-bit random operands, and a set of 32-bit corner patterns.

// File: rtl/sta_pkg.sv
package sta_pkg;

  localparam int unsigned GROUP_BITS = 4;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // generate/propagate of one bit position
  function automatic gp_t pair_of(input logic a, input logic b);
    gp_t r;
    r.g = a & b;
    r.p = a ^ b;
    return r;
  endfunction

  // black cell: hi span sits above lo span
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // gray cell: only the carry survives
  function automatic logic carry_through(input gp_t span, input logic c_lo);
    return span.g | (span.p & c_lo);
  endfunction

endpackage

// File: rtl/ks_prefix_net.sv
module ks_prefix_net
  import sta_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  gp_t [N-1:0] span_in,
  output gp_t [N-1:0] span_out
);

  localparam int unsigned LV = (N > 1) ? $clog2(N) : 0;

  gp_t [LV:0][N-1:0] stage;

  assign stage[0] = span_in;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < N; i++) begin : g_pos
      if (i >= D) begin : g_cell
        assign stage[l+1][i] = gp_merge(stage[l][i], stage[l][i-D]);
      end else begin : g_pass
        assign stage[l+1][i] = stage[l][i];
      end
    end
  end

  assign span_out = stage[LV];

  // a generate at the top of a span is never masked by the network
  always_comb begin
    if (!$isunknown(span_in)) begin
      for (int i = 0; i < N; i++) begin
        if (span_in[i].g) begin
          assert_span_gen_kept_R4: assert (span_out[i].g);
        end
      end
    end
  end

endmodule

// File: rtl/ripple_group.sv
module ripple_group
  import sta_pkg::*;
#(
  parameter int unsigned BITS = 4
) (
  input  gp_t [BITS-1:0] gp_in,
  input  logic           carry_in,
  output logic [BITS-1:0] sum_out,
  output logic           carry_out
);

  logic [BITS:0] chain;
  logic [BITS-1:0] prop_bits;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    assign chain[i+1]   = carry_through(gp_in[i], chain[i]);
    assign sum_out[i]   = gp_in[i].p ^ chain[i];
    assign prop_bits[i] = gp_in[i].p;
  end

  assign carry_out = chain[BITS];

  always_comb begin
    if (!$isunknown({gp_in, carry_in}) && (&prop_bits)) begin
      assert_ripple_pass_R5: assert (carry_out == carry_in);
    end
  end

endmodule

// File: rtl/full_tree_adder.sv
module full_tree_adder
  import sta_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  gp_t [WIDTH-1:0] bit_span;
  gp_t [WIDTH-1:0] bit_prefix;
  logic [WIDTH:0]  carry_at;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_span[i] = pair_of(a_in[i], b_in[i]);
  end

  ks_prefix_net #(.N(WIDTH)) u_bit_net (
    .span_in  (bit_span),
    .span_out (bit_prefix)
  );

  assign carry_at[0] = carry_in;
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign carry_at[i+1] = carry_through(bit_prefix[i], carry_in);
    assign sum_out[i]    = bit_span[i].p ^ carry_at[i];
  end

  assign carry_out = carry_at[WIDTH];

endmodule

// File: rtl/sparse_tree_adder.sv
module sparse_tree_adder
  import sta_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = GROUP_BITS
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  localparam int unsigned NG = WIDTH / GROUP;

  if ((WIDTH == 0) || (GROUP == 0) || (WIDTH % GROUP != 0)) begin : g_bad_width
    $error("sparse_tree_adder: WIDTH must be a nonzero multiple of GROUP");
  end

  // serial fold of one group's flags (associativity makes order free)
  function automatic gp_t fold_group(input gp_t [GROUP-1:0] v);
    gp_t acc;
    acc = v[0];
    for (int j = 1; j < GROUP; j++) acc = gp_merge(v[j], acc);
    return acc;
  endfunction

  gp_t [WIDTH-1:0] bit_span;
  gp_t [NG-1:0]    grp_span;
  gp_t [NG-1:0]    grp_prefix;
  logic [NG:0]     tree_carry;    // carry into bottom of group k
  logic [NG-1:0]   ripple_carry;  // carry leaving group k through its chain

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_span[i] = pair_of(a_in[i], b_in[i]);
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp_span
    assign grp_span[k] = fold_group(bit_span[k*GROUP +: GROUP]);
  end

  ks_prefix_net #(.N(NG)) u_group_net (
    .span_in  (grp_span),
    .span_out (grp_prefix)
  );

  assign tree_carry[0] = carry_in;
  for (genvar k = 0; k < NG; k++) begin : g_boundary
    assign tree_carry[k+1] = carry_through(grp_prefix[k], carry_in);
  end

  for (genvar k = 0; k < NG; k++) begin : g_section
    ripple_group #(.BITS(GROUP)) u_section (
      .gp_in     (bit_span[k*GROUP +: GROUP]),
      .carry_in  (tree_carry[k]),
      .sum_out   (sum_out[k*GROUP +: GROUP]),
      .carry_out (ripple_carry[k])
    );
  end

  assign carry_out = tree_carry[NG];

  // group hand-off between ripple chains and the tree
  always_comb begin
    if (!$isunknown({a_in, b_in, carry_in})) begin
      for (int k = 0; k < NG; k++) begin
        assert_group_handoff_R3: assert (ripple_carry[k] == tree_carry[k+1]);
        if (grp_span[k].g) begin
          assert_group_gen_R4: assert (tree_carry[k+1]);
        end
        if (grp_span[k].p) begin
          assert_group_prop_R4: assert (tree_carry[k+1] == tree_carry[k]);
        end
      end
    end
  end

  // closed-form port results
  always_comb begin
    if (!$isunknown({a_in, b_in, carry_in})) begin
      if ((a_in ^ b_in) == {WIDTH{1'b1}}) begin
        assert_full_propagate_R5: assert ((carry_out == carry_in) &&
          (sum_out == {WIDTH{~carry_in}}));
      end
      if ((b_in == '0) && !carry_in) begin
        assert_zero_operand_R6: assert ((sum_out == a_in) && !carry_out);
      end
      if ((a_in == '0) && (b_in == '0)) begin
        assert_both_zero_R6: assert ((sum_out == {{(WIDTH-1){1'b0}}, carry_in}) && !carry_out);
      end
      if ((a_in == {WIDTH{1'b1}}) && (b_in == {WIDTH{1'b1}})) begin
        assert_all_ones_R7: assert (carry_out &&
          (sum_out == {{(WIDTH-1){1'b1}}, carry_in}));
      end
    end
  end

endmodule

// File: tb/test_sparse_tree_adder.sv
module test_sparse_tree_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0, s32, sf32;
  logic        c32 = 1'b0, co32, cof32;
  logic [7:0]  a8 = '0, b8 = '0, s8, sf8;
  logic        c8 = 1'b0, co8, cof8;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [32:0] q32[$];
  logic [8:0]  q8[$];
  string       qtag[$];

  sparse_tree_adder #(.WIDTH(32)) i_sparse_tree_adder (
    .a_in(a32), .b_in(b32), .carry_in(c32), .sum_out(s32), .carry_out(co32));
  sparse_tree_adder #(.WIDTH(8)) i_sparse_tree_adder_w8 (
    .a_in(a8), .b_in(b8), .carry_in(c8), .sum_out(s8), .carry_out(co8));
  full_tree_adder #(.WIDTH(32)) i_full_tree_adder (
    .a_in(a32), .b_in(b32), .carry_in(c32), .sum_out(sf32), .carry_out(cof32));
  full_tree_adder #(.WIDTH(8)) i_full_tree_adder_w8 (
    .a_in(a8), .b_in(b8), .carry_in(c8), .sum_out(sf8), .carry_out(cof8));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one vector pair on a rising edge and queue the behavioural result
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input logic [7:0] x, input logic [7:0] y, input logic z,
                       input string tag);
    @(posedge clk);
    a32 = a; b32 = b; c32 = c;
    a8 = x;  b8 = y;  c8 = z;
    q32.push_back(33'(a) + 33'(b) + 33'(c));
    q8.push_back(9'(x) + 9'(y) + 9'(z));
    qtag.push_back(tag);
  endtask

  // compare at the falling edge, away from the edge that changes inputs
  always @(negedge clk) begin
    if (!rst && (q32.size() > 0)) begin
      logic [32:0] e32;
      logic [8:0]  e8;
      string       t;
      e32 = q32.pop_front();
      e8  = q8.pop_front();
      t   = qtag.pop_front();
      check({t, " R1 sum32"}, 33'(s32), 33'(e32[31:0]));
      check({t, " R2 cout32"}, 33'(co32), 33'(e32[32]));
      check({t, " R1 sum8"}, 33'(s8), 33'(e8[7:0]));
      check({t, " R2 cout8"}, 33'(co8), 33'(e8[8]));
      check({t, " R8 full32"}, {cof32, sf32}, {co32, s32});
      check({t, " R8 full8"}, 33'({cof8, sf8}), 33'({co8, s8}));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs give zero outputs (R6)
    check("R6 idle sum", 33'({co32, s32}), 33'd0);
    check("R6 idle sum8", 33'({co8, s8}), 33'd0);

    // R6: zero operands
    drive(32'h0, 32'h0, 1'b0, 8'h00, 8'h00, 1'b0, "R6");
    drive(32'h0, 32'h0, 1'b1, 8'h00, 8'h00, 1'b1, "R6");
    drive(32'h1234_5678, 32'h0, 1'b0, 8'h9C, 8'h00, 1'b0, "R6");
    drive(32'h0, 32'hCAFE_0001, 1'b1, 8'h00, 8'hFF, 1'b1, "R6");
    // R5: full carry propagation
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 8'hAA, 8'h55, 1'b0, "R5");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 8'hAA, 8'h55, 1'b1, "R5");
    drive(32'hFFFF_0000, 32'h0000_FFFF, 1'b1, 8'hF0, 8'h0F, 1'b1, "R5");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, 8'hFF, 8'h00, 1'b1, "R5");
    // R7: all ones plus all ones
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 8'hFF, 8'hFF, 1'b0, "R7");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 8'hFF, 8'hFF, 1'b1, "R7");
    // R3: carries crossing group boundaries
    drive(32'h0000_000F, 32'h0000_0001, 1'b0, 8'h0F, 8'h01, 1'b0, "R3");
    drive(32'h0FFF_FFFF, 32'h0000_0001, 1'b0, 8'h7F, 8'h01, 1'b0, "R3");
    drive(32'h7FFF_FFFF, 32'h0, 1'b1, 8'h0F, 8'h00, 1'b1, "R3");
    // R4: group generate, then a fully propagating group passing it on
    drive(32'h0000_0080, 32'h0000_0080, 1'b0, 8'h08, 8'h08, 1'b0, "R4");
    drive(32'h0000_00F8, 32'h0000_0008, 1'b0, 8'hF8, 8'h08, 1'b0, "R4");
    drive(32'hF0F0_F0F8, 32'h0000_0008, 1'b0, 8'hF8, 8'h08, 1'b0, "R4");
    // alternating bits added to themselves
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 8'h55, 8'h55, 1'b1, "R1");

    // R1/R8: exhaustive 8-bit alongside random 32-bit vectors
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int z = 0; z < 2; z++) begin
          drive($urandom, $urandom, 1'($urandom), 8'(x), 8'(y), 1'(z), "R1");
        end
      end
    end

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule